// File: doc/BRIEF.md
# Tileable Bit-Serial Processor Mesh

This block is a grid of single-bit processing elements, 6 rows by 12 columns. A controller outside the block sends one 20-bit instruction word each clock, and all 72 elements execute it in the same cycle. Each element holds four one-bit registers (NS, EW, C and CM), a small bit-addressed local memory, and a three-input adder/subtracter. That ALU reads NS, EW and C and produces a sum, a carry and a borrow. The instruction sets the source of every register and of the memory write. It also gives one memory address, which every element uses for both its read and its write in that cycle.

NS values pass between north and south neighbours, and EW values pass between east and west neighbours. On the boundary, an element that has no neighbour on one side reads an edge input port instead, and the register it exposes on that side drives the matching edge output. Arrays can therefore be tiled into a larger mesh. The CM registers form a separate path that shifts south, one row per cycle. It brings bit planes into the grid from the north and takes them out at the south. Multi-bit arithmetic runs bit-serially: operand planes come from memory, the carry stays in C, and each result plane goes back to memory.

Top module: `bitmesh_array`

## Requirements
- R1: The reset is synchronous and active high. It clears NS, EW, C and CM in every element. After an edge at which rst is high, every edge output and cm_out reads zero.
- R2: The ALU computes sum = NS^EW^C, carry = the majority of NS, EW and C, and borrow = 1 exactly when NS < EW + C (NS is the minuend). The C field is instr[13:12]: 0 holds, 1 loads the addressed memory bit, 2 loads carry, 3 loads borrow.
- R3: The NS field is instr[19:17]. Code 1 loads the NS of the neighbour to the north, with row 0 reading north_in[c]. Code 2 loads the NS of the neighbour to the south, with row 5 reading south_in[c]. Code 3 loads the element's own EW, 4 the memory bit and 5 its own CM. north_out[c] is the NS of row 0 and south_out[c] is the NS of row 5, with bit c standing for column c.
- R4: The EW field is instr[16:14]. Code 1 loads the EW of the neighbour to the west, with column 0 reading west_in[r]. Code 2 loads the EW of the neighbour to the east, with column 11 reading east_in[r]. Code 3 loads own NS, 4 the memory bit and 5 own CM. west_out[r] is the EW of column 0 and east_out[r] is the EW of column 11, with bit r standing for row r.
- R5: The CM field is instr[11:10]. Code 1 moves CM one row south, with row 0 taking cm_in[c]. Code 2 loads the memory bit and code 3 loads own NS. cm_out[c] is the CM of row 5.
- R6: Every source, whether a neighbour, the element's own register, the ALU or the memory, is sampled as it stood before the clock edge. For example, NS code 3 together with EW code 3 swaps the two registers, and a whole-array shift moves data exactly one position per cycle.
- R7: The address is instr[6:0], and its low log2(DEPTH) bits select the memory bit. The write field is instr[9:7]: 0 means no write, 1 sum, 2 carry, 3 borrow, 4 CM, 5 NS, 6 EW, 7 C. A read of the memory bit in the same instruction returns its content from before the write.
- R8: Code 0 in the NS, EW, C or CM field leaves that register unchanged, whatever the edge inputs do.
- R9: Codes 6 and 7 in the NS or EW field load a constant 0 or 1.
- R10: All 72 elements execute the same instruction in the same cycle. A bit-serial 4-bit add of two planes in memory therefore gives the correct per-element sum and carry-out in every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 20 | Instruction broadcast to all elements |
| north_in | input | 12 | NS value from the north, one bit per column |
| north_out | output | 12 | NS of row 0 |
| south_in | input | 12 | NS value from the south, one bit per column |
| south_out | output | 12 | NS of row 5 |
| east_in | input | 6 | EW value from the east, one bit per row |
| east_out | output | 6 | EW of column 11 |
| west_in | input | 6 | EW value from the west, one bit per row |
| west_out | output | 6 | EW of column 0 |
| cm_in | input | 12 | CM shift input into row 0 |
| cm_out | output | 12 | CM of row 5 |

## Verification
The hardest state to observe from the ports belongs to the 40 interior elements. Their registers and memory bits never appear on a boundary. To reach them, the bench writes the chosen register into memory, loads that memory plane into CM, and shifts south six times, comparing cm_out each cycle so that every element is checked. The same route exposes C and the ALU borrow, neither of which drives a port directly. It also exposes the read-before-write case, which the bench creates by loading NS from an address and writing NS to that same address in one instruction.

// File: rtl/bitmesh_pkg.sv
package bitmesh_pkg;

    localparam int INSTR_W = 20;
    localparam int ADDR_W  = 7;

    typedef enum logic [2:0] {
        NS_HOLD, NS_FROM_N, NS_FROM_S, NS_FROM_EW,
        NS_FROM_RAM, NS_FROM_CM, NS_ZERO, NS_ONE
    } ns_src_e;

    typedef enum logic [2:0] {
        EW_HOLD, EW_FROM_W, EW_FROM_E, EW_FROM_NS,
        EW_FROM_RAM, EW_FROM_CM, EW_ZERO, EW_ONE
    } ew_src_e;

    typedef enum logic [1:0] {
        C_HOLD, C_FROM_RAM, C_FROM_CARRY, C_FROM_BORROW
    } c_src_e;

    typedef enum logic [1:0] {
        CM_HOLD, CM_FROM_N, CM_FROM_RAM, CM_FROM_NS
    } cm_src_e;

    typedef enum logic [2:0] {
        WR_NONE, WR_SUM, WR_CARRY, WR_BORROW,
        WR_CM, WR_NS, WR_EW, WR_C
    } wr_src_e;

    typedef struct packed {
        ns_src_e             ns_src;
        ew_src_e             ew_src;
        c_src_e              c_src;
        cm_src_e             cm_src;
        wr_src_e             wr_src;
        logic [ADDR_W-1:0]   addr;
    } cmd_t;

    typedef struct packed {
        logic sum;
        logic carry;
        logic borrow;
    } alu_t;

    // Three-input add/subtract: NS is the minuend, EW and C the subtrahends.
    function automatic alu_t alu_eval(input logic ns, input logic ew, input logic c);
        alu_t o;
        o.sum    = ns ^ ew ^ c;
        o.carry  = (ns & ew) | (ns & c) | (ew & c);
        o.borrow = (~ns & (ew | c)) | (ew & c);
        return o;
    endfunction

endpackage

// File: rtl/bitmesh_decode.sv
module bitmesh_decode
    import bitmesh_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output cmd_t               cmd
);
    always_comb begin
        cmd.ns_src = ns_src_e'(instr[19:17]);
        cmd.ew_src = ew_src_e'(instr[16:14]);
        cmd.c_src  = c_src_e'(instr[13:12]);
        cmd.cm_src = cm_src_e'(instr[11:10]);
        cmd.wr_src = wr_src_e'(instr[9:7]);
        cmd.addr   = instr[ADDR_W-1:0];
    end
endmodule

// File: rtl/bitmesh_cell.sv
module bitmesh_cell
    import bitmesh_pkg::*;
#(
    parameter int DEPTH = 16
)(
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic n_ns,
    input  logic s_ns,
    input  logic w_ew,
    input  logic e_ew,
    input  logic n_cm,
    output logic ns_q,
    output logic ew_q,
    output logic c_q,
    output logic cm_q
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic             rd_bit;
    logic             wr_bit;
    logic             ns_d, ew_d, c_d, cm_d;
    alu_t             alu;
    logic             unused_addr;

    assign idx         = cmd.addr[IDX_W-1:0];
    assign unused_addr = ^cmd.addr;

    always_comb begin
        rd_bit = mem[idx];
        alu    = alu_eval(ns_q, ew_q, c_q);

        case (cmd.ns_src)
            NS_FROM_N:   ns_d = n_ns;
            NS_FROM_S:   ns_d = s_ns;
            NS_FROM_EW:  ns_d = ew_q;
            NS_FROM_RAM: ns_d = rd_bit;
            NS_FROM_CM:  ns_d = cm_q;
            NS_ZERO:     ns_d = 1'b0;
            NS_ONE:      ns_d = 1'b1;
            default:     ns_d = ns_q;
        endcase

        case (cmd.ew_src)
            EW_FROM_W:   ew_d = w_ew;
            EW_FROM_E:   ew_d = e_ew;
            EW_FROM_NS:  ew_d = ns_q;
            EW_FROM_RAM: ew_d = rd_bit;
            EW_FROM_CM:  ew_d = cm_q;
            EW_ZERO:     ew_d = 1'b0;
            EW_ONE:      ew_d = 1'b1;
            default:     ew_d = ew_q;
        endcase

        case (cmd.c_src)
            C_FROM_RAM:    c_d = rd_bit;
            C_FROM_CARRY:  c_d = alu.carry;
            C_FROM_BORROW: c_d = alu.borrow;
            default:       c_d = c_q;
        endcase

        case (cmd.cm_src)
            CM_FROM_N:   cm_d = n_cm;
            CM_FROM_RAM: cm_d = rd_bit;
            CM_FROM_NS:  cm_d = ns_q;
            default:     cm_d = cm_q;
        endcase

        case (cmd.wr_src)
            WR_SUM:    wr_bit = alu.sum;
            WR_CARRY:  wr_bit = alu.carry;
            WR_BORROW: wr_bit = alu.borrow;
            WR_CM:     wr_bit = cm_q;
            WR_NS:     wr_bit = ns_q;
            WR_EW:     wr_bit = ew_q;
            WR_C:      wr_bit = c_q;
            default:   wr_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q <= 1'b0;
            ew_q <= 1'b0;
            c_q  <= 1'b0;
            cm_q <= 1'b0;
        end else begin
            ns_q <= ns_d;
            ew_q <= ew_d;
            c_q  <= c_d;
            cm_q <= cm_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && (cmd.wr_src != WR_NONE))
            mem[idx] <= wr_bit;
    end

    // R8: a hold code keeps the register
    assert_ns_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.ns_src == NS_HOLD) |=> (ns_q == $past(ns_q)));

    // R2: C takes the majority of the pre-edge operands
    assert_c_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd.c_src == C_FROM_CARRY) |=>
            (c_q == (($past(ns_q) & $past(ew_q)) | ($past(ns_q) & $past(c_q)) | ($past(ew_q) & $past(c_q)))));

    // R7: an NS write lands at the addressed bit
    assert_ram_write_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr_src == WR_NS) |=> (mem[$past(idx)] == $past(ns_q)));

endmodule

// File: rtl/bitmesh_array.sv
module bitmesh_array
    import bitmesh_pkg::*;
#(
    parameter int ROWS  = 6,
    parameter int COLS  = 12,
    parameter int DEPTH = 16
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic [COLS-1:0]    north_in,
    output logic [COLS-1:0]    north_out,
    input  logic [COLS-1:0]    south_in,
    output logic [COLS-1:0]    south_out,
    input  logic [ROWS-1:0]    east_in,
    output logic [ROWS-1:0]    east_out,
    input  logic [ROWS-1:0]    west_in,
    output logic [ROWS-1:0]    west_out,
    input  logic [COLS-1:0]    cm_in,
    output logic [COLS-1:0]    cm_out
);
    localparam int LAST_R = ROWS - 1;
    localparam int LAST_C = COLS - 1;

    cmd_t cmd;

    logic ns_grid [ROWS][COLS];
    logic ew_grid [ROWS][COLS];
    logic c_grid  [ROWS][COLS];
    logic cm_grid [ROWS][COLS];

    logic [COLS-1:0] cm_row_above_last;
    logic [ROWS-1:0] ew_col_before_last;

    bitmesh_decode u_dec (
        .instr (instr),
        .cmd   (cmd)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic n_ns, s_ns, w_ew, e_ew, n_cm;

            if (r == 0) begin : g_top
                assign n_ns = north_in[c];
                assign n_cm = cm_in[c];
            end else begin : g_inner_n
                assign n_ns = ns_grid[r-1][c];
                assign n_cm = cm_grid[r-1][c];
            end

            if (r == LAST_R) begin : g_bottom
                assign s_ns = south_in[c];
            end else begin : g_inner_s
                assign s_ns = ns_grid[r+1][c];
            end

            if (c == 0) begin : g_left
                assign w_ew = west_in[r];
            end else begin : g_inner_w
                assign w_ew = ew_grid[r][c-1];
            end

            if (c == LAST_C) begin : g_right
                assign e_ew = east_in[r];
            end else begin : g_inner_e
                assign e_ew = ew_grid[r][c+1];
            end

            bitmesh_cell #(.DEPTH(DEPTH)) u_cell (
                .clk  (clk),
                .rst  (rst),
                .cmd  (cmd),
                .n_ns (n_ns),
                .s_ns (s_ns),
                .w_ew (w_ew),
                .e_ew (e_ew),
                .n_cm (n_cm),
                .ns_q (ns_grid[r][c]),
                .ew_q (ew_grid[r][c]),
                .c_q  (c_grid[r][c]),
                .cm_q (cm_grid[r][c])
            );
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_ns_edge
        assign north_out[c]         = ns_grid[0][c];
        assign south_out[c]         = ns_grid[LAST_R][c];
        assign cm_out[c]            = cm_grid[LAST_R][c];
        assign cm_row_above_last[c] = cm_grid[(LAST_R > 0) ? LAST_R - 1 : 0][c];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_ew_edge
        assign west_out[r]           = ew_grid[r][0];
        assign east_out[r]           = ew_grid[r][LAST_C];
        assign ew_col_before_last[r] = ew_grid[r][(LAST_C > 0) ? LAST_C - 1 : 0];
    end

    // R1: reset leaves all boundary views at zero
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (north_out == '0 && south_out == '0 && east_out == '0 &&
                        west_out == '0 && cm_out == '0));

    // R3: a southward NS move puts the north edge input into row 0
    assert_ns_from_north_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.ns_src == NS_FROM_N) |=> (north_out == $past(north_in)));

    // R3: a northward NS move puts the south edge input into the last row
    assert_ns_from_south_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.ns_src == NS_FROM_S) |=> (south_out == $past(south_in)));

    // R4: an eastward EW move advances exactly one column
    assert_ew_east_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.ew_src == EW_FROM_W) |=> (east_out == $past(ew_col_before_last) &&
                                      west_out == $past(west_in)));

    // R5: a CM shift advances every row exactly one step south
    assert_cm_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd.cm_src == CM_FROM_N) |=> (cm_out == $past(cm_row_above_last)));

endmodule

// File: tb/bitmesh_array_test.sv
`timescale 1ns/1ps
module bitmesh_array_test;
    localparam int ROWS  = 6;
    localparam int COLS  = 12;
    localparam int DEPTH = 16;

    // field codes as stated in the requirements
    localparam int NSC_N = 1, NSC_S = 2, NSC_EW = 3, NSC_RAM = 4, NSC_CM = 5, NSC_0 = 6, NSC_1 = 7;
    localparam int EWC_W = 1, EWC_E = 2, EWC_NS = 3, EWC_RAM = 4, EWC_CM = 5, EWC_0 = 6, EWC_1 = 7;
    localparam int CC_RAM = 1, CC_CARRY = 2, CC_BORROW = 3;
    localparam int CMC_N = 1, CMC_RAM = 2, CMC_NS = 3;
    localparam int WRC_SUM = 1, WRC_CARRY = 2, WRC_BORROW = 3, WRC_CM = 4, WRC_NS = 5, WRC_EW = 6, WRC_C = 7;

    function automatic logic [19:0] mk(int ns, int ew, int c, int cm, int wr, int a);
        return {ns[2:0], ew[2:0], c[1:0], cm[1:0], wr[2:0], a[6:0]};
    endfunction

    // directed transfer vectors, tags in comments
    localparam int NVEC = 10;
    localparam logic [19:0] VEC [NVEC] = '{
        {3'd7, 3'd6, 2'd0, 2'd3, 3'd0, 7'd0},  // R9: NS=1, EW=0, CM<=NS
        {3'd1, 3'd0, 2'd0, 2'd0, 3'd0, 7'd0},  // R3: from north
        {3'd2, 3'd0, 2'd0, 2'd0, 3'd0, 7'd0},  // R3: from south
        {3'd0, 3'd1, 2'd0, 2'd0, 3'd0, 7'd0},  // R4: from west
        {3'd0, 3'd2, 2'd0, 2'd0, 3'd0, 7'd0},  // R4: from east
        {3'd3, 3'd3, 2'd0, 2'd0, 3'd0, 7'd0},  // R6: swap
        {3'd1, 3'd1, 2'd0, 2'd1, 3'd0, 7'd0},  // R6: simultaneous shifts
        {3'd0, 3'd0, 2'd0, 2'd0, 3'd0, 7'd0},  // R8: hold everything
        {3'd5, 3'd5, 2'd0, 2'd0, 3'd0, 7'd0},  // R3: NS<=CM, EW<=CM
        {3'd6, 3'd7, 2'd0, 2'd0, 3'd0, 7'd0}   // R9: NS=0, EW=1
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 9:    return "R9";
            1, 2, 8: return "R3";
            3, 4:    return "R4";
            5, 6:    return "R6";
            default: return "R8";
        endcase
    endfunction

    logic            clk = 1'b0;
    logic            rst;
    logic [19:0]     drv_instr;
    logic [COLS-1:0] drv_n, drv_s, drv_cm;
    logic [ROWS-1:0] drv_e, drv_w;
    logic [COLS-1:0] north_out, south_out, cm_out;
    logic [ROWS-1:0] east_out, west_out;

    always #4 clk = ~clk;

    bitmesh_array #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) uut (
        .clk       (clk),
        .rst       (rst),
        .instr     (drv_instr),
        .north_in  (drv_n),
        .north_out (north_out),
        .south_in  (drv_s),
        .south_out (south_out),
        .east_in   (drv_e),
        .east_out  (east_out),
        .west_in   (drv_w),
        .west_out  (west_out),
        .cm_in     (drv_cm),
        .cm_out    (cm_out)
    );

    // reference state
    bit m_ns [ROWS][COLS];
    bit m_ew [ROWS][COLS];
    bit m_c  [ROWS][COLS];
    bit m_cm [ROWS][COLS];
    bit m_mem[ROWS][COLS][DEPTH];

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;

    task automatic model_clock(input logic [19:0] ins);
        bit nn [ROWS][COLS];
        bit ne [ROWS][COLS];
        bit nc [ROWS][COLS];
        bit nm [ROWS][COLS];
        int a;
        a = int'(ins[3:0]);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                bit ns, ew, cy, cmv, rd, sm, ca, bo, up_ns, dn_ns, lf_ew, rt_ew, up_cm, wv;
                ns = m_ns[r][c]; ew = m_ew[r][c]; cy = m_c[r][c]; cmv = m_cm[r][c];
                rd = m_mem[r][c][a];
                sm = ns ^ ew ^ cy;
                ca = (int'(ns) + int'(ew) + int'(cy)) >= 2;
                bo = int'(ns) < int'(ew) + int'(cy);
                up_ns = (r == 0) ? drv_n[c] : m_ns[r-1][c];
                dn_ns = (r == ROWS-1) ? drv_s[c] : m_ns[r+1][c];
                lf_ew = (c == 0) ? drv_w[r] : m_ew[r][c-1];
                rt_ew = (c == COLS-1) ? drv_e[r] : m_ew[r][c+1];
                up_cm = (r == 0) ? drv_cm[c] : m_cm[r-1][c];
                case (int'(ins[19:17]))
                    NSC_N: nn[r][c] = up_ns;   NSC_S: nn[r][c] = dn_ns;
                    NSC_EW: nn[r][c] = ew;     NSC_RAM: nn[r][c] = rd;
                    NSC_CM: nn[r][c] = cmv;    NSC_0: nn[r][c] = 0;
                    NSC_1: nn[r][c] = 1;       default: nn[r][c] = ns;
                endcase
                case (int'(ins[16:14]))
                    EWC_W: ne[r][c] = lf_ew;   EWC_E: ne[r][c] = rt_ew;
                    EWC_NS: ne[r][c] = ns;     EWC_RAM: ne[r][c] = rd;
                    EWC_CM: ne[r][c] = cmv;    EWC_0: ne[r][c] = 0;
                    EWC_1: ne[r][c] = 1;       default: ne[r][c] = ew;
                endcase
                case (int'(ins[13:12]))
                    CC_RAM: nc[r][c] = rd;     CC_CARRY: nc[r][c] = ca;
                    CC_BORROW: nc[r][c] = bo;  default: nc[r][c] = cy;
                endcase
                case (int'(ins[11:10]))
                    CMC_N: nm[r][c] = up_cm;   CMC_RAM: nm[r][c] = rd;
                    CMC_NS: nm[r][c] = ns;     default: nm[r][c] = cmv;
                endcase
                case (int'(ins[9:7]))
                    WRC_SUM: wv = sm;     WRC_CARRY: wv = ca;
                    WRC_BORROW: wv = bo;  WRC_CM: wv = cmv;
                    WRC_NS: wv = ns;      WRC_EW: wv = ew;
                    WRC_C: wv = cy;       default: wv = rd;
                endcase
                if (ins[9:7] != 3'd0) m_mem[r][c][a] = wv;
            end
        end
        m_ns = nn; m_ew = ne; m_c = nc; m_cm = nm;
    endtask

    task automatic compare(input string tag);
        logic [47:0] exp_v, act_v;
        logic [COLS-1:0] en, es, ec;
        logic [ROWS-1:0] ee, ew;
        for (int c = 0; c < COLS; c++) begin
            en[c] = m_ns[0][c]; es[c] = m_ns[ROWS-1][c]; ec[c] = m_cm[ROWS-1][c];
        end
        for (int r = 0; r < ROWS; r++) begin
            ee[r] = m_ew[r][COLS-1]; ew[r] = m_ew[r][0];
        end
        exp_v = {en, es, ee, ew, ec};
        act_v = {north_out, south_out, east_out, west_out, cm_out};
        n_checks++;
        if (act_v !== exp_v) begin
            n_fails++;
            $display("FAIL %s: edges actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [19:0] ins, input string tag);
        drv_instr = ins;
        @(posedge clk);
        model_clock(ins);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drv_instr = '0;
        @(posedge clk);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) begin
                m_ns[r][c] = 0; m_ew[r][c] = 0; m_c[r][c] = 0; m_cm[r][c] = 0;
            end
        @(negedge clk);
        rst = 1'b0;
        compare("R1");
    endtask

    function automatic logic [COLS-1:0] pat(int p, int r);
        int v;
        v = (p * 73 + r * 151 + 29) ^ (p * r * 19) ^ 12'hA5C;
        return v[COLS-1:0];
    endfunction

    task automatic load_plane(input int a);
        for (int k = ROWS - 1; k >= 0; k--) begin
            drv_cm = pat(a, k);
            step(mk(0, 0, 0, CMC_N, 0, 0), "R5");
        end
        step(mk(0, 0, 0, 0, WRC_CM, a), "R7");
    endtask

    task automatic unload_plane(input int a, input string tag);
        step(mk(0, 0, 0, CMC_RAM, 0, a), tag);
        for (int k = 0; k < ROWS; k++) begin
            drv_cm = pat(k, 99);
            step(mk(0, 0, 0, CMC_N, 0, 0), tag);
        end
    endtask

    initial begin
        rst = 1'b1;
        drv_instr = '0;
        drv_n = '0; drv_s = '0; drv_e = '0; drv_w = '0; drv_cm = '0;
        @(negedge clk);
        do_reset();

        // table of transfer vectors with varying edge inputs
        for (int i = 0; i < NVEC; i++) begin
            drv_n  = pat(i, 1);
            drv_s  = pat(i, 2);
            drv_e  = pat(i, 3)[ROWS-1:0];
            drv_w  = pat(i, 4)[ROWS-1:0];
            drv_cm = pat(i, 5);
            step(VEC[i], vec_tag(i));
        end

        // operand planes A at 0..3, B at 4..7
        for (int a = 0; a < 8; a++) load_plane(a);
        unload_plane(2, "R7");

        // bit-serial add: clear C, then four bit steps
        step(mk(NSC_0, EWC_0, 0, 0, 0, 0), "R9");
        step(mk(0, 0, CC_CARRY, 0, 0, 0), "R2");
        for (int i = 0; i < 4; i++) begin
            step(mk(NSC_RAM, 0, 0, 0, 0, i), "R10");
            step(mk(0, EWC_RAM, 0, 0, 0, 4 + i), "R10");
            step(mk(0, 0, CC_CARRY, 0, WRC_SUM, 8 + i), "R10");
        end
        step(mk(0, 0, 0, 0, WRC_C, 12), "R2");
        for (int a = 8; a <= 12; a++) unload_plane(a, "R10");

        // borrow and carry of the final operand state
        step(mk(0, 0, 0, 0, WRC_BORROW, 14), "R2");
        unload_plane(14, "R2");
        step(mk(0, 0, CC_BORROW, 0, WRC_CARRY, 15), "R2");
        step(mk(0, 0, 0, 0, WRC_C, 15), "R2");
        unload_plane(15, "R2");

        // read-before-write on one address
        step(mk(NSC_RAM, 0, 0, 0, WRC_NS, 1), "R7");
        unload_plane(1, "R7");
        step(mk(0, 0, 0, 0, WRC_NS, 3), "R7");
        unload_plane(3, "R7");

        // hold with busy edges, then check the plane is untouched
        drv_n = 12'hFFF; drv_s = 12'hFFF; drv_e = '1; drv_w = '1;
        step(mk(0, 0, 0, 0, 0, 3), "R8");
        unload_plane(3, "R8");

        // one-step east shift, then read back every EW
        step(mk(0, EWC_RAM, 0, 0, 0, 9), "R4");
        drv_w = 6'b101101;
        step(mk(0, EWC_W, 0, 0, 0, 0), "R4");
        step(mk(0, 0, 0, 0, WRC_EW, 13), "R4");
        unload_plane(13, "R4");

        // NS moved north by one, read back through CM
        step(mk(NSC_RAM, 0, 0, 0, 0, 10), "R3");
        drv_s = 12'h3C6;
        step(mk(NSC_S, 0, 0, 0, 0, 0), "R3");
        step(mk(0, 0, 0, CMC_NS, 0, 0), "R5");
        for (int k = 0; k < ROWS; k++) step(mk(0, 0, 0, CMC_N, 0, 0), "R5");

        // reset in mid-run clears everything
        step(mk(NSC_1, EWC_1, 0, 0, 0, 0), "R9");
        do_reset();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule